// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one input capture channel for a timer subsystem. A signal on an external pin is first resynchronised into the clock domain. On a qualifying transition the block records the current value of one of two free-running 16-bit time bases. The recorded values wait in a four-deep queue. Software drains the queue one word at a time with a read strobe. Each strobe presents the oldest value, and the rest move forward one position.

A control word written through a simple strobe sets up the channel. It selects the edge mode, which of the two time bases is sampled, how many captures must occur before the interrupt flag pulses, and whether the channel stops while the system is idle. Three modes behave differently from the rest. The every-edge mode interrupts on each capture and never reports overflow. The wake-only mode stores nothing and acts as an external interrupt pin with a wake output. A full queue that takes one more event in a counting mode raises an overflow and stops storing until it has been emptied.

Top module: `icap_channel`

## Requirements
- R1: The queue holds four entries. `cap_data_o` always shows the oldest stored entry. A `rd_stb_i` pulse while the queue is non-empty removes that entry and moves the others forward, so values come out in capture order.
- R2: `buf_ne_o` is 0 after reset. It goes to 1 with the first stored capture and returns to 0 only when every stored capture has been read. A read of an empty queue has no effect on the flags, and its data is unspecified.
- R3: If an event arrives in a storing mode other than every-edge while four entries are held and no read happens in that cycle, `ovf_o` goes to 1 and the new value is dropped.
- R4: While `ovf_o` is 1, no capture is stored. `ovf_o` returns to 0 when the last held entry is read, and captures are then stored again.
- R5: Control bit 7 picks the time base: 0 (the reset value) samples `tmr_b_i`, and 1 samples `tmr_a_i`.
- R6: Mode 3'b001 (control bits 2:0) captures on both rising and falling pin edges. It pulses `irq_o` on every such edge whatever the count field holds, and never sets `ovf_o`. If the queue is full, the value is dropped silently.
- R7: Control bits 6:5 hold a count n. In modes 010 to 101, `irq_o` pulses once per n+1 stored captures, and the capture counter restarts after each pulse.
- R8: Mode 3'b111 reacts to rising edges only and stores nothing. Each edge pulses `irq_o`, and pulses `wake_o` as well when `int_en_i` is 1. This mode still runs when the idle stop would otherwise halt the channel.
- R9: Mode 3'b100 captures on every 4th rising edge and mode 3'b101 on every 16th. The value taken is the time base at the edge that completes the count.
- R10: Mode 3'b010 captures falling edges only and mode 3'b011 rising edges only. Mode 3'b000 produces no events or interrupts and clears both the prescale counter and the capture counter.
- R11: When control bit 13 is 1 and `idle_i` is 1, pin edges produce no captures in modes 001 to 101. With bit 13 at 0 the channel keeps capturing in idle.
- R12: A pin change present before clock edge k is stored by clock edge k+2. `buf_ne_o`, `irq_o` and `wake_o` show the result after that edge, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word: mode [2:0], count [6:5], time base select [7], idle stop [13] |
| idle_i | input | 1 | System is in idle |
| int_en_i | input | 1 | Interrupt enable used to qualify wake |
| tmr_a_i | input | 16 | First time base value |
| tmr_b_i | input | 16 | Second time base value (default source) |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| rd_stb_i | input | 1 | Read strobe that pops the oldest entry |
| cap_data_o | output | 16 | Oldest stored capture |
| buf_ne_o | output | 1 | Queue holds at least one entry |
| ovf_o | output | 1 | Overflow occurred, storing frozen until drained |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wake_o | output | 1 | One-cycle wake pulse in wake-only mode |

## Verification
A pin change reaches the queue two clock edges after it is first sampled. The flags, the interrupt pulse and the wake pulse all appear after that same edge. A control write or a read strobe takes effect at the next edge. The bench therefore drives every input on the falling clock edge. After each pin change it waits four falling edges before it samples results, and it counts one-cycle pulses with a monitor so that none are missed. One dedicated check samples just before and just after the edge on which a capture is due. This pins down the exact synchroniser delay.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [2:0] {
    M_OFF   = 3'b000,
    M_BOTH  = 3'b001,
    M_FALL  = 3'b010,
    M_RISE  = 3'b011,
    M_DIV4  = 3'b100,
    M_DIV16 = 3'b101,
    M_RSV   = 3'b110,
    M_WAKE  = 3'b111
  } icap_mode_e;

  typedef struct packed {
    icap_mode_e  mode;
    logic [1:0]  icnt;
    logic        tsel;
    logic        istop;
  } icap_cfg_t;

  localparam int MODE_LSB  = 0;
  localparam int ICNT_LSB  = 5;
  localparam int TSEL_BIT  = 7;
  localparam int ISTOP_BIT = 13;

  function automatic icap_cfg_t decode_ctrl(input logic [15:0] w);
    icap_cfg_t c;
    c.mode  = icap_mode_e'(w[MODE_LSB +: 3]);
    c.icnt  = w[ICNT_LSB +: 2];
    c.tsel  = w[TSEL_BIT];
    c.istop = w[ISTOP_BIT];
    return c;
  endfunction

  // terminal value of the prescale counter for a divided mode
  function automatic logic [3:0] ps_last(input icap_mode_e m);
    return (m == M_DIV16) ? 4'd15 : 4'd3;
  endfunction

  // true when the capture about to be stored completes the interrupt count
  function automatic logic irq_due(input logic [1:0] cnt, input logic [1:0] icnt);
    return cnt == icnt;
  endfunction

  function automatic logic is_storing(input icap_mode_e m);
    return (m == M_BOTH) || (m == M_FALL) || (m == M_RISE) ||
           (m == M_DIV4) || (m == M_DIV16);
  endfunction

endpackage

// File: rtl/icap_edge_sync.sv
module icap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  logic synced, prev;
  assign synced = sh_q[SYNC_STAGES-1];
  assign prev   = sh_q[SYNC_STAGES];
  assign rise_o = synced & ~prev;
  assign fall_o = ~synced & prev;
endmodule

// File: rtl/icap_event_gen.sv
module icap_event_gen
  import icap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  icap_mode_e mode_i,
  input  logic       halt_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);
  logic [3:0] ps_q;
  logic       divided, ps_wrap;

  assign divided = (mode_i == M_DIV4) || (mode_i == M_DIV16);
  assign ps_wrap = ps_q >= ps_last(mode_i);

  always_comb begin
    evt_o = 1'b0;
    if (!halt_i) begin
      unique case (mode_i)
        M_BOTH:          evt_o = rise_i | fall_i;
        M_FALL:          evt_o = fall_i;
        M_RISE, M_WAKE:  evt_o = rise_i;
        M_DIV4, M_DIV16: evt_o = rise_i & ps_wrap;
        default:         evt_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ps_q <= '0;
    else if (mode_i == M_OFF)            ps_q <= '0;
    else if (divided && rise_i && !halt_i) ps_q <= ps_wrap ? 4'd0 : ps_q + 4'd1;
  end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             din_i,
  input  logic                          rd_i,
  input  logic                          ovf_en_i,
  output logic [DATA_W-1:0]             dout_o,
  output logic [$clog2(DEPTH+1)-1:0]    fill_o,
  output logic                          ovf_o,
  output logic                          accept_o
);
  localparam int FILL_W = $clog2(DEPTH+1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [FILL_W-1:0] fill_q, wptr;
  logic              frozen_q, do_rd, full, ovf_evt;

  assign full     = fill_q == FULL;
  assign do_rd    = rd_i && (fill_q != '0);
  assign accept_o = wr_i && !frozen_q && (!full || do_rd);
  assign ovf_evt  = wr_i && ovf_en_i && !frozen_q && full && !do_rd;
  assign wptr     = do_rd ? fill_q - FILL_W'(1) : fill_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem_q[i] <= '0;
      else if (accept_o && wptr == FILL_W'(i))     mem_q[i] <= din_i;
      else if (do_rd && i < DEPTH-1)               mem_q[i] <= mem_q[(i < DEPTH-1) ? i+1 : i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      fill_q <= fill_q + FILL_W'(accept_o) - FILL_W'(do_rd);
      if (ovf_evt)                                    frozen_q <= 1'b1;
      else if (do_rd && fill_q == FILL_W'(1) && !accept_o) frozen_q <= 1'b0;
    end
  end

  assign dout_o = mem_q[0];
  assign fill_o = fill_q;
  assign ovf_o  = frozen_q;
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic [15:0]       ctrl_wdata_i,
  input  logic              idle_i,
  input  logic              int_en_i,
  input  logic [DATA_W-1:0] tmr_a_i,
  input  logic [DATA_W-1:0] tmr_b_i,
  input  logic              cap_pin_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              buf_ne_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int FILL_W = $clog2(DEPTH+1);

  icap_cfg_t cfg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '{mode: M_OFF, icnt: 2'd0, tsel: 1'b0, istop: 1'b0};
    else if (ctrl_we_i) cfg_q <= decode_ctrl(ctrl_wdata_i);
  end

  // named internal events, also observed by the checker
  logic              pin_rise, pin_fall, halt, cap_evt, fifo_wr, fifo_accept, fire;
  logic              counted;
  logic [2:0]        mode_bits;
  logic [FILL_W-1:0] fill;
  logic [DATA_W-1:0] tb_val;
  logic [1:0]        evt_cnt_q;

  assign mode_bits = cfg_q.mode;
  assign halt      = idle_i && cfg_q.istop && (cfg_q.mode != M_WAKE);
  assign tb_val    = cfg_q.tsel ? tmr_a_i : tmr_b_i;

  icap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  icap_event_gen u_evt (
    .clk(clk), .rst_n(rst_n), .mode_i(cfg_q.mode), .halt_i(halt),
    .rise_i(pin_rise), .fall_i(pin_fall), .evt_o(cap_evt)
  );

  assign fifo_wr = cap_evt && is_storing(cfg_q.mode);
  assign counted = is_storing(cfg_q.mode) && (cfg_q.mode != M_BOTH);

  icap_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_i(fifo_wr), .din_i(tb_val), .rd_i(rd_stb_i),
    .ovf_en_i(cfg_q.mode != M_BOTH), .dout_o(cap_data_o), .fill_o(fill),
    .ovf_o(ovf_o), .accept_o(fifo_accept)
  );

  assign fire = (cap_evt && (cfg_q.mode == M_BOTH || cfg_q.mode == M_WAKE)) ||
                (counted && fifo_accept && irq_due(evt_cnt_q, cfg_q.icnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt_q <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      if (cfg_q.mode == M_OFF)
        evt_cnt_q <= '0;
      else if (counted && fifo_accept)
        evt_cnt_q <= irq_due(evt_cnt_q, cfg_q.icnt) ? 2'd0 : evt_cnt_q + 2'd1;
      irq_o  <= fire;
      wake_o <= cap_evt && (cfg_q.mode == M_WAKE) && int_en_i;
    end
  end

  assign buf_ne_o = fill != '0;
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int DEPTH  = 4,
  parameter int FILL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_bits,
  input logic              rd_stb_i,
  input logic [FILL_W-1:0] fill,
  input logic              fifo_wr,
  input logic              ovf_o,
  input logic              buf_ne_o,
  input logic              irq_o,
  input logic              wake_o
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH)); // R1

  AST_LAST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && fill == FILL_W'(1) && !fifo_wr) |=> !buf_ne_o); // R2

  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(fill) == FILL_W'(DEPTH)); // R3

  AST_FROZEN_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !rd_stb_i) |=> fill == $past(fill)); // R4

  AST_BOTH_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 3'b001) |=> !$rose(ovf_o)); // R6

  AST_WAKE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(mode_bits) == 3'b111); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 3'b000) |=> !irq_o); // R10
endmodule

bind icap_channel icap_channel_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .rd_stb_i(rd_stb_i),
  .fill(fill), .fifo_wr(fifo_wr), .ovf_o(ovf_o), .buf_ne_o(buf_ne_o),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/icap_channel_tb.sv
module icap_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctrl_we = 1'b0, idle = 1'b0, int_en = 1'b0, pin = 1'b0, rd = 1'b0;
  logic [15:0] ctrl_wdata = '0, tmr_a = '0, tmr_b = '0;
  logic [15:0] cap_data;
  logic        buf_ne, ovf, irq, wake;
  int          checks = 0, errors = 0, irq_cnt = 0, wake_cnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_channel dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .idle_i(idle), .int_en_i(int_en), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .cap_pin_i(pin), .rd_stb_i(rd), .cap_data_o(cap_data), .buf_ne_o(buf_ne),
    .ovf_o(ovf), .irq_o(irq), .wake_o(wake)
  );

  always @(posedge clk) begin
    if (irq)  irq_cnt++;
    if (wake) wake_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // control word: mode [2:0], count [6:5], base select [7], idle stop [13]
  task automatic set_ctrl(input logic [2:0] m, input logic [1:0] n, input logic ts, input logic is);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = {2'b00, is, 5'b0, ts, n, 2'b00, m};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_pin();
    drive_pin(1'b1);
    drive_pin(1'b0);
  endtask

  task automatic pop(input string req, input logic [15:0] exp, input bit check_data);
    @(negedge clk);
    if (check_data) chk(req, cap_data, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset ne", buf_ne, 0);
    chk("R3 reset ovf", ovf, 0);
    chk("R8 reset irq/wake", {irq, wake}, 0);

    // R12 latency and R5 default time base
    set_ctrl(3'b011, 2'd0, 1'b0, 1'b0);
    tmr_a = 16'hAAAA; tmr_b = 16'h1111;
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R12 not yet stored", buf_ne, 0);
    @(negedge clk); chk("R12 stored at k+2", buf_ne, 1);
    chk("R12 irq with capture", irq, 1);
    drive_pin(1'b0);
    chk("R10 rise mode ignores fall", dut_i.buf_ne_o == 1'b1 && !ovf, 1);
    pop("R5 default base b", 16'h1111, 1);
    set_ctrl(3'b011, 2'd0, 1'b1, 1'b0);
    pulse_pin();
    pop("R5 select base a", 16'hAAAA, 1);
    chk("R2 drained", buf_ne, 0);

    // R10 falling edge mode
    set_ctrl(3'b010, 2'd0, 1'b0, 1'b0);
    tmr_b = 16'h2222;
    drive_pin(1'b1);
    chk("R10 fall mode ignores rise", buf_ne, 0);
    drive_pin(1'b0);
    chk("R10 fall captured", buf_ne, 1);
    pop("R10 fall data", 16'h2222, 1);

    // R1 R3 R4 overflow and freeze
    set_ctrl(3'b011, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tmr_b = 16'h0100 + 16'(i);
      pulse_pin();
      chk("R3 ovf timing", ovf, (i == 4) ? 1 : 0);
    end
    pop("R1 oldest first", 16'h0100, 1);
    tmr_b = 16'h0200;
    pulse_pin();
    chk("R4 frozen still set", ovf, 1);
    for (int i = 1; i < 4; i++) pop("R1 R3 order, fifth dropped", 16'h0100 + 16'(i), 1);
    chk("R4 ovf clears on drain", ovf, 0);
    chk("R4 frozen capture not stored", buf_ne, 0);
    tmr_b = 16'h0300;
    pulse_pin();
    pop("R4 captures resume", 16'h0300, 1);

    // R6 every edge mode
    set_ctrl(3'b001, 2'd3, 1'b0, 1'b0);
    irq_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      tmr_b = 16'h0400 + 16'(i);
      drive_pin(~pin);
    end
    chk("R6 irq every edge", irq_cnt, 6);
    chk("R6 no overflow", ovf, 0);
    for (int i = 0; i < 4; i++) pop("R6 first four kept", 16'h0400 + 16'(i), 1);
    chk("R6 extra values dropped", buf_ne, 0);

    // R7 interrupt count sweep
    for (int n = 0; n < 4; n++) begin
      set_ctrl(3'b000, 2'd0, 1'b0, 1'b0);
      set_ctrl(3'b011, 2'(n), 1'b0, 1'b0);
      irq_cnt = 0;
      for (int i = 0; i < 8; i++) begin
        tmr_b = 16'h0700 + 16'(8*n + i);
        pulse_pin();
        pop("R7 data", 16'h0700 + 16'(8*n + i), 1);
      end
      chk("R7 irq per n+1 captures", irq_cnt, 8 / (n + 1));
    end

    // R9 divide by 4 and by 16
    set_ctrl(3'b000, 2'd0, 1'b0, 1'b0);
    set_ctrl(3'b100, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tmr_b = 16'h0500 + 16'(i);
      pulse_pin();
      if (i == 2) chk("R9 div4 none before 4th", buf_ne, 0);
    end
    pop("R9 div4 4th edge", 16'h0503, 1);
    pop("R9 div4 8th edge", 16'h0507, 1);
    set_ctrl(3'b000, 2'd0, 1'b0, 1'b0);
    set_ctrl(3'b101, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      tmr_b = 16'h0600 + 16'(i);
      pulse_pin();
      if (i == 14) chk("R9 div16 none before 16th", buf_ne, 0);
    end
    pop("R9 div16 16th edge", 16'h060F, 1);
    chk("R9 div16 single capture", buf_ne, 0);

    // R8 wake mode
    set_ctrl(3'b111, 2'd3, 1'b0, 1'b1);
    idle = 1'b1; int_en = 1'b1;
    irq_cnt = 0; wake_cnt = 0;
    pulse_pin();
    chk("R8 wake with enable, in idle", wake_cnt, 1);
    chk("R8 irq each edge", irq_cnt, 1);
    chk("R8 stores nothing", buf_ne, 0);
    int_en = 1'b0;
    pulse_pin();
    chk("R8 no wake without enable", wake_cnt, 1);
    chk("R8 irq still", irq_cnt, 2);

    // R11 idle stop
    set_ctrl(3'b011, 2'd0, 1'b0, 1'b1);
    pulse_pin();
    chk("R11 halted in idle", buf_ne, 0);
    set_ctrl(3'b011, 2'd0, 1'b0, 1'b0);
    tmr_b = 16'h0800;
    pulse_pin();
    pop("R11 runs in idle when bit 13 clear", 16'h0800, 1);
    idle = 1'b0;

    // R2 empty read has no effect on flags
    pop("R2 empty read", 16'h0, 0);
    chk("R2 empty read flags", {buf_ne, ovf}, 0);

    // R10 off mode is quiet
    set_ctrl(3'b000, 2'd0, 1'b0, 1'b0);
    irq_cnt = 0;
    pulse_pin();
    chk("R10 off no irq", irq_cnt, 0);
    chk("R10 off no capture", buf_ne, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule